// File: doc/BRIEF.md
# Serial Control Register Port

This block gives a host microcontroller serial access to a small bank of 8-bit control registers. One shift clock serves both directions. A write is framed by an active-low write strobe. A read is framed by an active-low read strobe. Both directions use the same serial data input line: a write carries a register address followed by a data byte, and a read carries only the address. During a read, the addressed register is shifted back out on a serial output, and that output is released whenever no read is in progress.

All register contents are presented in parallel as one flat bus, so the neighbouring blocks can decode mute, level, tone and ringer fields from it. One configurable bit of the bank also drives a general-purpose latch output pin. An active-low reset loads a parameterised image into the bank, and the bank keeps that image until the host writes to it.

Top module: `ctl_serial_regs`

## Requirements
- R1: While `rst_n` is low, and from then until the first write, every register holds the value given by `RESET_IMAGE`. The default image puts 0x80 in registers 0 and 1 and 0x00 in registers 2 to 7. Bit 7 of register 0 is the transmit mute and bit 7 of register 1 is the receive mute.
- R2: While `wr_n` is low and `rd_n` is high, `sdi` is sampled on each rising edge of `sclk`. The sampled frame is a 3-bit register address followed by 8 data bits, each sent MSB first.
- R3: A write is committed on the first rising `sclk` edge that sees `wr_n` high after it was low. From the next sample point onward, register n appears on `reg_bus[8n+7:8n]`.
- R4: A write frame of any length other than exactly 11 bits changes no register.
- R5: While `rd_n` is low and `wr_n` is high, the first three `sdi` bits are taken as the address. Bit 7 of that register is on `cdo` after the third rising edge, and each later rising edge moves to the next lower bit, down to bit 0.
- R6: `cdo_en` is low whenever `rd_n` is high. While it is low, the output pad does not drive, which is its high-impedance state.
- R7: If `wr_n` and `rd_n` are low on the same edge, the write in progress is discarded and no register changes. `cdo_en` is low on that edge and for the rest of that read.
- R8: `latch_o` follows bit 0 of register 7. A write can set it to 1 or clear it to 0.
- R9: A committed write changes only the addressed register, and all registers hold their values between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Shift clock shared by reads and writes |
| rst_n | input | 1 | Asynchronous active-low reset of the bank |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| sdi | input | 1 | Serial address and data input, MSB first |
| cdo | output | 1 | Serial read data, MSB first |
| cdo_en | output | 1 | Drive enable for the serial output pad |
| reg_bus | output | 64 | All registers in parallel, register n at bits 8n+7..8n |
| latch_o | output | 1 | General-purpose latch pin (register 7, bit 0) |

## Verification
A write and a read can meet in the same shift-clock cycle, because the two strobes are independent pins. The bench provokes this in two ways. First, it pulls the read strobe low for a single cycle in the middle of a write frame and then checks that the target register on the parallel bus keeps its old value. Second, it pulls the write strobe low in the middle of a read and checks that the output enable drops at once. Frames one bit too short and one bit too long are also sent, to confirm that the exact-length rule alone decides a commit.

// File: rtl/ctlser_pkg.sv
package ctlser_pkg;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } rd_phase_e;

  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  function automatic rd_phase_e rd_phase(input int unsigned cnt, input int unsigned aw,
                                         input int unsigned dw);
    if (cnt < aw)           return PH_ADDR;
    else if (cnt < aw + dw) return PH_DATA;
    else                    return PH_DONE;
  endfunction

  // Bit of the register presented after cnt rising edges of a read.
  function automatic int unsigned rd_bit_index(input int unsigned cnt, input int unsigned aw,
                                               input int unsigned dw);
    return aw + dw - 1 - cnt;
  endfunction

endpackage

// File: rtl/ctlser_wr.sv
module ctlser_wr
  import ctlser_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          sdi,
  output logic          commit,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata
);
  localparam int unsigned FRAME = AW + DW;
  localparam int unsigned CW    = $clog2(FRAME + 2);

  logic [FRAME-1:0] sh;
  logic [CW-1:0]    cnt;
  logic             wr_n_q;
  logic             abort;
  logic             wr_act;
  logic             clash;
  logic             wr_end;

  assign wr_act = ~wr_n & rd_n;
  assign clash  = ~wr_n & ~rd_n;
  assign wr_end = wr_n & ~wr_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      wr_n_q <= 1'b1;
      abort  <= 1'b0;
    end else begin
      wr_n_q <= wr_n;
      if (wr_n) begin
        cnt   <= '0;
        abort <= 1'b0;
      end else if (wr_act) begin
        sh  <= {sh[FRAME-2:0], sdi};
        cnt <= CW'(sat_inc(int'(cnt), FRAME + 1));
      end else begin
        abort <= 1'b1;
      end
    end
  end

  assign commit = wr_end & (int'(cnt) == FRAME) & ~abort;
  assign waddr  = sh[FRAME-1:DW];
  assign wdata  = sh[DW-1:0];

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |=> (sh[0] == $past(sdi)));

  a_r7_clash_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> $stable(sh));

  a_r7_clash_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> !commit);

endmodule

// File: rtl/ctlser_rd.sv
module ctlser_rd
  import ctlser_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          sdi,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic          cdo,
  output logic          cdo_en
);
  localparam int unsigned FRAME = AW + DW;
  localparam int unsigned CW    = $clog2(FRAME + 2);
  localparam int unsigned IW    = (DW > 1) ? $clog2(DW) : 1;

  logic [CW-1:0] rcnt;
  logic          rabort;
  logic          rd_act;
  rd_phase_e     phase;
  logic [IW-1:0] idx;

  assign rd_act = ~rd_n & wr_n;
  assign phase  = rd_phase(int'(rcnt), AW, DW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt   <= '0;
      raddr  <= '0;
      rabort <= 1'b0;
    end else if (rd_n) begin
      rcnt   <= '0;
      rabort <= 1'b0;
    end else if (rd_act) begin
      if (phase == PH_ADDR) raddr <= {raddr[AW-2:0], sdi};
      rcnt <= CW'(sat_inc(int'(rcnt), FRAME + 1));
    end else begin
      rabort <= 1'b1;
    end
  end

  always_comb begin
    idx = '0;
    cdo = 1'b0;
    if (phase == PH_DATA) begin
      idx = IW'(rd_bit_index(int'(rcnt), AW, DW));
      cdo = rdata[idx];
    end
  end

  assign cdo_en = rd_act & ~rabort;

  a_r5_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && phase == PH_ADDR) |=> (raddr[0] == $past(sdi)));

  a_r6_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> !cdo_en);

  a_r7_read_killed: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |=> (rd_n || !cdo_en));

endmodule

// File: rtl/ctlser_bank.sv
module ctlser_bank #(
  parameter int unsigned AW   = 3,
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 8,
  parameter logic [NREG*DW-1:0] RESET_IMAGE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [AW-1:0]      raddr,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] reg_bus
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        regs[i] <= RESET_IMAGE[i*DW +: DW];
      else if (we && waddr == AW'(i))    regs[i] <= wdata;
    end
    assign reg_bus[i*DW +: DW] = regs[i];
  end

  assign rdata = (int'(raddr) < NREG) ? regs[raddr] : '0;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(reg_bus));

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (regs[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/ctl_serial_regs.sv
module ctl_serial_regs
  import ctlser_pkg::*;
#(
  parameter int unsigned AW        = 3,
  parameter int unsigned DW        = 8,
  parameter int unsigned NREG      = 8,
  parameter int unsigned LATCH_REG = 7,
  parameter int unsigned LATCH_BIT = 0,
  parameter logic [NREG*DW-1:0] RESET_IMAGE = 64'h0000_0000_0000_8080
) (
  input  logic               sclk,
  input  logic               rst_n,
  input  logic               wr_n,
  input  logic               rd_n,
  input  logic               sdi,
  output logic               cdo,
  output logic               cdo_en,
  output logic [NREG*DW-1:0] reg_bus,
  output logic               latch_o
);
  logic          wr_commit;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          clash_ev;

  assign clash_ev = ~wr_n & ~rd_n;

  ctlser_wr #(.AW(AW), .DW(DW)) u_wr (
    .clk(sclk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .sdi(sdi),
    .commit(wr_commit), .waddr(wr_addr), .wdata(wr_data)
  );

  ctlser_rd #(.AW(AW), .DW(DW)) u_rd (
    .clk(sclk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .sdi(sdi),
    .rdata(rd_data), .raddr(rd_addr), .cdo(cdo), .cdo_en(cdo_en)
  );

  ctlser_bank #(.AW(AW), .DW(DW), .NREG(NREG), .RESET_IMAGE(RESET_IMAGE)) u_bank (
    .clk(sclk), .rst_n(rst_n), .we(wr_commit), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data), .reg_bus(reg_bus)
  );

  assign latch_o = reg_bus[LATCH_REG*DW + LATCH_BIT];

  a_r7_clash_no_change: assert property (@(posedge sclk) disable iff (!rst_n)
    clash_ev |=> $stable(reg_bus));

  a_r4_commit_needs_strobe_rise: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_commit |-> (wr_n && $past(!wr_n)));

  a_r8_latch_changes_by_write: assert property (@(posedge sclk) disable iff (!rst_n)
    !wr_commit |=> $stable(latch_o));

endmodule

// File: tb/ctl_serial_regs_bench.sv
module ctl_serial_regs_bench;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        sdi = 1'b0;
  logic        cdo;
  logic        cdo_en;
  logic [63:0] reg_bus;
  logic        latch_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] model [8];
  int         exp_q[$];
  int         act_q[$];
  string      tag_q[$];

  always #2.5 sclk = ~sclk;

  ctl_serial_regs u_ctl_serial_regs (
    .sclk(sclk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .sdi(sdi),
    .cdo(cdo), .cdo_en(cdo_en), .reg_bus(reg_bus), .latch_o(latch_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_bus();
    logic [63:0] b;
    for (int i = 0; i < 8; i++) b[i*8 +: 8] = model[i];
    return b;
  endfunction

  task automatic load_image();
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    model[0] = 8'h80;
    model[1] = 8'h80;
  endtask

  // Driver: sends n bits MSB first; read strobe also low on bit clash_at.
  task automatic wr_bits(input logic [11:0] v, input int n, input int clash_at);
    for (int k = 0; k < n; k++) begin
      @(negedge sclk);
      wr_n = 1'b0;
      sdi  = v[n-1-k];
      rd_n = (k == clash_at) ? 1'b0 : 1'b1;
    end
    @(negedge sclk);
    wr_n = 1'b1;
    rd_n = 1'b1;
    @(negedge sclk);
    if (n == 11 && clash_at < 0) model[v[10:8]] = v[7:0];
  endtask

  // Driver: pushes the expected byte, then shifts the address and gathers the reply.
  task automatic rd_reg(input logic [2:0] a, input string req);
    logic [7:0] got;
    exp_q.push_back(int'(model[a]));
    tag_q.push_back(req);
    for (int k = 0; k < 3; k++) begin
      @(negedge sclk);
      rd_n = 1'b0;
      sdi  = a[2-k];
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge sclk);
      got[7-k] = cdo;
      if (k == 0) check("R5 enable during data", 64'(cdo_en), 64'd1);
    end
    act_q.push_back(int'(got));
    rd_n = 1'b1;
    @(negedge sclk);
    check("R6 released after read", 64'(cdo_en), 64'd0);
  endtask

  // Monitor: pops and compares as results arrive.
  always @(negedge sclk) begin
    if (act_q.size() > 0 && exp_q.size() > 0) begin
      int a;
      int e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, 64'(a), 64'(e));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge sclk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    load_image();
    repeat (3) @(negedge sclk);
    check("R1 image in reset", reg_bus, model_bus());
    check("R6 idle released", 64'(cdo_en), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge sclk);
    check("R1 image kept after reset", reg_bus, model_bus());
    check("R8 latch default", 64'(latch_o), 64'd0);

    rd_reg(3'd0, "R1 read reset value reg0");
    rd_reg(3'd1, "R1 read reset value reg1");

    wr_bits({1'b0, 3'd2, 8'h5A}, 11, -1);
    check("R3 R2 write reg2", reg_bus, model_bus());
    rd_reg(3'd2, "R5 read reg2");
    wr_bits({1'b0, 3'd5, 8'hC3}, 11, -1);
    check("R9 only reg5 changed", reg_bus, model_bus());
    rd_reg(3'd5, "R5 read reg5");
    wr_bits({1'b0, 3'd7, 8'h01}, 11, -1);
    check("R8 latch set", 64'(latch_o), 64'd1);

    wr_bits({2'b0, 3'd3, 7'h55}, 10, -1);
    check("R4 short frame ignored", reg_bus, model_bus());
    wr_bits({1'b1, 3'd3, 8'hAA}, 12, -1);
    check("R4 long frame ignored", reg_bus, model_bus());

    wr_bits({1'b0, 3'd4, 8'hE7}, 11, 5);
    check("R7 clash write discarded", reg_bus, model_bus());

    // r7_ read interrupted by the write strobe
    @(negedge sclk);
    rd_n = 1'b0;
    sdi  = 1'b1;
    @(negedge sclk);
    wr_n = 1'b0;
    @(negedge sclk);
    wr_n = 1'b1;
    @(negedge sclk);
    check("R7 read output dropped", 64'(cdo_en), 64'd0);
    rd_n = 1'b1;
    @(negedge sclk);
    check("R7 bus unchanged after read clash", reg_bus, model_bus());

    wr_bits({1'b0, 3'd7, 8'hFE}, 11, -1);
    check("R8 latch cleared", 64'(latch_o), 64'd0);
    wr_bits({1'b0, 3'd0, 8'hFF}, 11, -1);
    rd_reg(3'd0, "R5 read reg0 all ones");
    rd_reg(3'd5, "R9 reg5 held");
    check("R9 whole bus", reg_bus, model_bus());

    rst_n = 1'b0;
    load_image();
    @(negedge sclk);
    check("R1 async reset restores image", reg_bus, model_bus());
    rst_n = 1'b1;
    repeat (4) @(negedge sclk);
    finish_run();
  end
endmodule